// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

A bank of single-bit hardware semaphores that several processors share through their own register ports. A lock is taken by reading it: if the read returns 0, the lock was free and the read has just made it taken, so the reader now owns it. If the read returns 1, someone else holds it and the reader tries again later. The owner gives the lock back by writing the value 0 to the same word. Reads take effect atomically, so there is no window between testing a lock and claiming it.

Each requester has its own 32-bit register port with a byte address, read and write strobes, write data, read data and a ready flag. Every access is answered exactly one cycle after it is presented, so a requester may poll on every cycle. A read-only identification word tells software how many locks the bank was built with. When several ports read the same free lock in the same cycle, a fixed-priority rule gives it to the lowest-numbered port.

Top module: `spinlock_bank`

## Requirements
- R1: After synchronous active-low reset every lock is free and every port shows ready low with read data 0.
- R2: A read of a free lock answers, one cycle later with ready high, read data 0 (bits 31:1 always 0), and leaves that lock taken from the same clock edge.
- R3: A read of a taken lock answers read data 1 and leaves the lock taken.
- R4: A write of 0 to a lock frees it, and a read of that lock in the very next cycle acquires it again.
- R5: A write of any nonzero value to a lock changes nothing; a later read still returns 1.
- R6: When several ports read the same free lock in one cycle, only the lowest-numbered of them receives 0; all others receive 1.
- R7: A read and a release of the same lock in one cycle: the read sees the state from before that cycle; a taken lock ends free (read returns 1), a free lock ends taken by the reader (read returns 0).
- R8: A read of byte address 0x014 returns the lock count divided by 32 in bits 31:24 (1, 2, 4 or 8 for 32, 64, 128 or 256 locks) and 0 in all other bits; writes there change nothing.
- R9: An access to any other address, including a misaligned one or one past the last lock, gets ready, returns 0 and changes no lock.
- R10: Every access is answered exactly one cycle later with ready high, and accesses may be presented on every cycle with no gap.
- R11: Lock i is the 32-bit word at byte address 0x800 + 4*i on a 12-bit address.
- R12: A port that raises both strobes in one cycle performs only the read; its write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | NPORT*12 | Byte address per port, port p at bits [12p+11:12p] |
| bus_rd | input | NPORT | Read strobe per port |
| bus_wr | input | NPORT | Write strobe per port |
| bus_wdata | input | NPORT*32 | Write data per port |
| bus_rdata | output | NPORT*32 | Read data per port, valid with ready |
| bus_ready | output | NPORT | Access answered, one cycle after the strobe |

## Verification
The bench drives contention on a handful of locks from three ports at once. An arbiter that let two winners through would hand 0 to two ports for one lock. One that chose the wrong port would give the 0 to a higher-numbered port. It releases and re-reads locks on adjacent cycles and mixes a release with a read of the same lock in one cycle. A design that delayed its state update or gave release priority would return a stale 1 there, or leave a freshly claimed lock free. Nonzero writes, writes to misaligned addresses next to a held lock, and both strobes at once are aimed at a decoder that frees locks it should not touch. The bench sweeps every lock address and the boundary just past the last one to catch off-by-one decoding.

// File: rtl/spinlock_pkg.sv
// Shared constants and types for the spinlock bank.
// Assumes a 12-bit byte address and 32-bit data on every port.
package spinlock_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] LOCK_BASE   = 12'h800;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h014;

    // What a port's address selects.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_LOCK   = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

    // Identification word: lock count / 32 in bits 31:24, rest zero.
    function automatic logic [BUS_W-1:0] status_word(input int num_locks);
        logic [7:0] field;
        field = 8'(num_locks / 32);
        return {field, 24'h0};
    endfunction
endpackage

// File: rtl/sl_decode.sv
// Address decoder for one requester port.
// Classifies the access, extracts the lock index and raises claim or
// release requests. Assumes NUM_LOCKS is 32, 64, 128 or 256.
module sl_decode
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 64,
    localparam int IDX_W = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              claim,
    output logic              free_req
);
    localparam logic [ADDR_W-1:0] LOCK_END = LOCK_BASE + ADDR_W'(4 * NUM_LOCKS);

    logic in_lock;

    // Word-aligned address inside the lock window.
    assign in_lock = (addr >= LOCK_BASE) && (addr < LOCK_END) && (addr[1:0] == 2'b00);

    // Lock index is the word offset from the window base.
    assign idx = IDX_W'((addr - LOCK_BASE) >> 2);

    // Select the access kind from the address.
    always_comb begin
        if (in_lock)                   kind = ACC_LOCK;
        else if (addr == STATUS_ADDR)  kind = ACC_STATUS;
        else                           kind = ACC_NONE;
    end

    // A read claims; a pure write of zero releases (read wins when both strobe).
    assign claim    = rd && (kind == ACC_LOCK);
    assign free_req = wr && !rd && (kind == ACC_LOCK) && (wdata == '0);
endmodule

// File: rtl/sl_claim_arb.sv
// Fixed-priority claim arbiter.
// A port wins when its lock is free and no lower-numbered port claims the
// same lock in this cycle. Purely combinational.
module sl_claim_arb #(
    parameter int NPORT = 2,
    parameter int IDX_W = 6
) (
    input  logic [NPORT-1:0]            claim,
    input  logic [NPORT-1:0][IDX_W-1:0] claim_idx,
    input  logic [NPORT-1:0]            busy,
    output logic [NPORT-1:0]            won
);
    // Lowest port index takes a contended free lock.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            won[p] = claim[p] && !busy[p];
            for (int q = 0; q < p; q++) begin
                if (claim[q] && (claim_idx[q] == claim_idx[p]))
                    won[p] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sl_lock_array.sv
// Storage for the lock bits.
// Reports the current state of each port's addressed lock, sets locks that
// the arbiter granted and clears locks that a port released. A grant and a
// release of one lock in one cycle leave it taken.
module sl_lock_array #(
    parameter int NUM_LOCKS = 64,
    parameter int NPORT     = 2,
    localparam int IDX_W = $clog2(NUM_LOCKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0][IDX_W-1:0] look_idx,
    input  logic [NPORT-1:0]            won,
    input  logic [NPORT-1:0]            rel,
    output logic [NPORT-1:0]            busy
);
    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] set_v;
    logic [NUM_LOCKS-1:0] clr_v;

    // Current state of the lock each port addresses.
    always_comb begin
        for (int p = 0; p < NPORT; p++)
            busy[p] = lock_q[look_idx[p]];
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        logic [NPORT-1:0] hit;
        logic             clr;

        // Gather grants and releases aimed at this lock.
        always_comb begin
            hit = '0;
            clr = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                if (won[p] && (look_idx[p] == IDX_W'(i))) hit[p] = 1'b1;
                if (rel[p] && (look_idx[p] == IDX_W'(i))) clr = 1'b1;
            end
        end
        assign set_v[i] = |hit;
        assign clr_v[i] = clr;

        p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));
        p_claim_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> lock_q[i]);
        p_taken_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q[i] && !clr_v[i]) |=> lock_q[i]);
        p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[i] && !set_v[i]) |=> !lock_q[i]);
        p_no_double_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[i] |-> !set_v[i]);
    end

    // Lock state update: grants set, releases clear, grants win a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= set_v | (lock_q & ~clr_v);
    end
endmodule

// File: rtl/spinlock_bank.sv
// Multi-port hardware spinlock bank.
// Each port reads a lock word to test-and-claim it and writes 0 to free it.
// Every access is answered one cycle later. Assumes NUM_LOCKS is one of
// 32, 64, 128, 256 and that ports hold their strobes for a single cycle
// per access.
module spinlock_bank
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 64,
    parameter int NPORT     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT*ADDR_W-1:0]  bus_addr,
    input  logic [NPORT-1:0]         bus_rd,
    input  logic [NPORT-1:0]         bus_wr,
    input  logic [NPORT*BUS_W-1:0]   bus_wdata,
    output logic [NPORT*BUS_W-1:0]   bus_rdata,
    output logic [NPORT-1:0]         bus_ready
);
    localparam int               IDX_W      = $clog2(NUM_LOCKS);
    localparam logic [BUS_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

    acc_kind_e                   kind [NPORT];
    logic [NPORT-1:0][IDX_W-1:0] idx;
    logic [NPORT-1:0]            claim;
    logic [NPORT-1:0]            rel;
    logic [NPORT-1:0]            busy;
    logic [NPORT-1:0]            won;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [BUS_W-1:0] rdata_q;
        logic             ready_q;

        sl_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec (
            .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
            .rd       (bus_rd[p]),
            .wr       (bus_wr[p]),
            .wdata    (bus_wdata[p*BUS_W +: BUS_W]),
            .kind     (kind[p]),
            .idx      (idx[p]),
            .claim    (claim[p]),
            .free_req (rel[p])
        );

        // Register the one-cycle answer for this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ready_q <= 1'b0;
                rdata_q <= '0;
            end else begin
                ready_q <= bus_rd[p] || bus_wr[p];
                rdata_q <= '0;
                if (bus_rd[p]) begin
                    case (kind[p])
                        ACC_LOCK:   rdata_q <= {{(BUS_W-1){1'b0}}, !won[p]};
                        ACC_STATUS: rdata_q <= STATUS_VAL;
                        default:    rdata_q <= '0;
                    endcase
                end
            end
        end

        assign bus_rdata[p*BUS_W +: BUS_W] = rdata_q;
        assign bus_ready[p]                = ready_q;

        p_lock_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
            claim[p] |=> (bus_ready[p] && (bus_rdata[p*BUS_W+1 +: BUS_W-1] == '0)));
        p_loser_sees_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (claim[p] && !won[p]) |=> bus_rdata[p*BUS_W]);
        p_status_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd[p] && (kind[p] == ACC_STATUS)) |=> (bus_rdata[p*BUS_W +: BUS_W] == STATUS_VAL));
        p_undecoded_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((bus_rd[p] || bus_wr[p]) && (kind[p] == ACC_NONE)) |=> (bus_ready[p] && (bus_rdata[p*BUS_W +: BUS_W] == '0)));
        p_no_free_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd[p] |-> !rel[p]);
    end

    sl_claim_arb #(.NPORT(NPORT), .IDX_W(IDX_W)) u_arb (
        .claim     (claim),
        .claim_idx (idx),
        .busy      (busy),
        .won       (won)
    );

    sl_lock_array #(.NUM_LOCKS(NUM_LOCKS), .NPORT(NPORT)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_idx (idx),
        .won      (won),
        .rel      (rel),
        .busy     (busy)
    );
endmodule

// File: tb/tb_spinlock_bank.sv
// Bench: behavioural lock model stepped once per cycle, compared on every clock.
module tb_spinlock_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_LOCKS  = 64;
    localparam int NPORT      = 3;
    localparam int AW         = 12;
    localparam int DW         = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AW-1:0] d_addr  [NPORT];
    logic          d_rd    [NPORT];
    logic          d_wr    [NPORT];
    logic [DW-1:0] d_wdata [NPORT];

    logic [NPORT*AW-1:0] bus_addr;
    logic [NPORT-1:0]    bus_rd, bus_wr;
    logic [NPORT*DW-1:0] bus_wdata;
    logic [NPORT*DW-1:0] bus_rdata;
    logic [NPORT-1:0]    bus_ready;

    for (genvar p = 0; p < NPORT; p++) begin : g_pack
        assign bus_addr[p*AW +: AW]  = d_addr[p];
        assign bus_rd[p]             = d_rd[p];
        assign bus_wr[p]             = d_wr[p];
        assign bus_wdata[p*DW +: DW] = d_wdata[p];
    end

    spinlock_bank #(.NUM_LOCKS(NUM_LOCKS), .NPORT(NPORT)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    bit            mdl [NUM_LOCKS];
    logic [DW-1:0] exp_data [NPORT];
    logic          exp_rdy  [NPORT];
    string         scen = "R1";
    int            n_chk = 0;
    int            n_fail = 0;

    function automatic logic [AW-1:0] lock_addr(input int i);
        return AW'(32'h800 + 4 * i);
    endfunction

    task automatic idle_all();
        for (int p = 0; p < NPORT; p++) begin
            d_addr[p] = '0; d_rd[p] = 1'b0; d_wr[p] = 1'b0; d_wdata[p] = '0;
        end
    endtask

    task automatic rd(input int p, input logic [AW-1:0] a);
        d_addr[p] = a; d_rd[p] = 1'b1;
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] v);
        d_addr[p] = a; d_wr[p] = 1'b1; d_wdata[p] = v;
    endtask

    // Model of one cycle: answers from pre-cycle state, ports served in index order.
    task automatic model_step();
        bit claimed [NUM_LOCKS];
        bit freed   [NUM_LOCKS];
        for (int i = 0; i < NUM_LOCKS; i++) begin claimed[i] = 0; freed[i] = 0; end
        for (int p = 0; p < NPORT; p++) begin
            int  a = int'(d_addr[p]);
            bit  is_lock = (a >= 'h800) && (a < 'h800 + 4*NUM_LOCKS) && (a % 4 == 0);
            int  li = (a - 'h800) / 4;
            exp_rdy[p]  = d_rd[p] || d_wr[p];
            exp_data[p] = '0;
            if (d_rd[p]) begin
                if (is_lock) begin
                    if (!mdl[li] && !claimed[li]) begin
                        claimed[li] = 1; exp_data[p] = 0;
                    end else begin
                        exp_data[p] = 1;
                    end
                end else if (a == 'h14) begin
                    exp_data[p] = DW'(NUM_LOCKS / 32) << 24;
                end
            end else if (d_wr[p] && is_lock && d_wdata[p] == 0) begin
                freed[li] = 1;
            end
        end
        for (int i = 0; i < NUM_LOCKS; i++)
            mdl[i] = claimed[i] | (mdl[i] & !freed[i]);
    endtask

    task automatic check_outputs();
        for (int p = 0; p < NPORT; p++) begin
            logic [DW-1:0] act = bus_rdata[p*DW +: DW];
            n_chk++;
            if (act !== exp_data[p] || bus_ready[p] !== exp_rdy[p]) begin
                n_fail++;
                $display("FAIL %s port %0d: rdata %h ready %b, expected rdata %h ready %b",
                         scen, p, act, bus_ready[p], exp_data[p], exp_rdy[p]);
            end
        end
    endtask

    // One cycle: model the driven inputs, let the edge pass, compare, go idle.
    task automatic tick();
        model_step();
        @(negedge clk);
        check_outputs();
        idle_all();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        idle_all();
        for (int i = 0; i < NUM_LOCKS; i++) mdl[i] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held.
        n_chk++;
        if (bus_ready !== '0 || bus_rdata !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: ready %b rdata %h, expected all zero", bus_ready, bus_rdata);
        end
        rst_n = 1'b1;
        for (int p = 0; p < NPORT; p++) begin exp_rdy[p] = 0; exp_data[p] = 0; end
        tick();

        // R11 R10 R1 R2: back-to-back sweep acquires every lock once.
        scen = "R11 R10 R1 R2";
        for (int i = 0; i < NUM_LOCKS; i++) begin rd(0, lock_addr(i)); tick(); end
        // R3: second sweep from another port sees every lock taken.
        scen = "R3";
        for (int i = 0; i < NUM_LOCKS; i++) begin rd(1, lock_addr(i)); tick(); end
        // R9: just past the last lock, misaligned, below the window.
        scen = "R9";
        rd(0, lock_addr(NUM_LOCKS)); rd(1, 12'h802); rd(2, 12'h7FC); tick();
        rd(0, 12'h000); wr(1, 12'h825, 32'h0); wr(2, lock_addr(NUM_LOCKS), 32'h0); tick();
        rd(0, lock_addr(9)); tick();
        // R4: release all, then reacquire lock 5 in the next cycle.
        scen = "R4";
        for (int i = 0; i < NUM_LOCKS; i++) begin wr(2, lock_addr(i), 32'h0); tick(); end
        rd(1, lock_addr(5)); tick();
        wr(0, lock_addr(5), 32'h0); tick();
        rd(2, lock_addr(5)); tick();
        // R5: nonzero writes leave a held lock held.
        scen = "R5";
        wr(0, lock_addr(5), 32'hFFFF_FFFF); tick();
        wr(1, lock_addr(5), 32'h1); tick();
        rd(0, lock_addr(5)); tick();
        // R6: contention for one free lock.
        scen = "R6";
        rd(0, lock_addr(9)); rd(1, lock_addr(9)); rd(2, lock_addr(9)); tick();
        rd(0, lock_addr(13)); rd(1, lock_addr(12)); rd(2, lock_addr(12)); tick();
        rd(0, lock_addr(9)); rd(2, lock_addr(9)); tick();
        wr(0, lock_addr(12), 32'h0); tick();
        rd(1, lock_addr(12)); rd(2, lock_addr(12)); tick();
        // R7: read and release of one lock in the same cycle.
        scen = "R7";
        wr(0, lock_addr(9), 32'h0); rd(1, lock_addr(9)); tick();
        rd(2, lock_addr(9)); tick();
        rd(0, lock_addr(20)); wr(1, lock_addr(20), 32'h0); tick();
        rd(2, lock_addr(20)); tick();
        // R8: identification word, and writes to it are dropped.
        scen = "R8";
        rd(2, 12'h014); tick();
        wr(0, 12'h014, 32'hDEAD_BEEF); wr(1, 12'h014, 32'h0); tick();
        rd(0, 12'h014); rd(1, 12'h014); tick();
        // R12: both strobes act as a read only.
        scen = "R12";
        d_addr[0] = lock_addr(20); d_rd[0] = 1'b1; d_wr[0] = 1'b1; d_wdata[0] = '0; tick();
        rd(1, lock_addr(20)); tick();
        d_addr[2] = lock_addr(40); d_rd[2] = 1'b1; d_wr[2] = 1'b1; d_wdata[2] = '0; tick();
        rd(0, lock_addr(40)); tick();
        // R6 R7 R4: random traffic on a few locks from all ports.
        scen = "R6 R7 R4 random";
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < NPORT; p++) begin
                int r = $urandom_range(0, 99);
                logic [AW-1:0] a = lock_addr($urandom_range(0, 3));
                if (r < 5) a = 12'h014;
                if (r < 50)      rd(p, a);
                else if (r < 80) wr(p, a, (r < 75) ? 32'h0 : 32'h1);
            end
            tick();
        end
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end
endmodule